// File: doc/BRIEF.md
# Residue-to-Binary Converter with Signed Compare

This block turns a seven-digit residue code back into an ordinary two's-complement integer. The moduli are 11, 23, 31, 73, 89, 127 and 128. They are pairwise coprime, and their product M = 828340264576 exceeds 2^39. Because the moduli are coprime, each integer in [0, M-1] owns exactly one code. A set that shares a factor, such as {2, 4}, would give 0 and 4 the same code (0, 0). The block rebuilds the integer with the Chinese remainder theorem: every digit is multiplied by a constant weight fixed at elaboration, and the products are summed. The sum is then reduced modulo M through a chain of pipelined conditional subtractions of M scaled by powers of two. A result at or above M/2 is read as negative and becomes X - M. The signed range is therefore [-M/2, M/2 - 1], which holds every signed 34-bit value with room to spare.

A residue code has no magnitude ordering of its own. The block therefore also has a compare mode. In that mode, two codes presented together are both converted, and the two signed results are compared to give less-than, equal and greater-than flags for operand A against operand B. The block is fully pipelined and accepts one input per cycle.

Top module: `rns_to_bin_cmp`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_lt`, `out_eq` and `out_gt` are 0 until a result arrives.
- R2: Each operand bus packs seven 7-bit digits. Bits [7i+6:7i] hold the residue for modulus i, with moduli in the order 11, 23, 31, 73, 89, 127, 128 for i = 0 to 6. For a code of X with 0 <= X < M/2, `out_value` equals X.
- R3: For a code of X with M/2 <= X <= M-1, `out_value` equals X - M as a 40-bit two's-complement number. In particular, M/2 gives -M/2 and M-1 gives -1.
- R4: `out_valid` rises exactly 12 clock cycles after `in_valid` is sampled high. Inputs on consecutive cycles produce results on consecutive cycles, in the same order.
- R5: With `in_cmp` = 1, exactly one of `out_lt`, `out_eq` and `out_gt` is 1 alongside `out_valid`. The asserted flag gives the signed order of operand A against operand B.
- R6: With `in_cmp` = 0, or whenever `out_valid` is 0, all three compare flags are 0. In convert mode, `out_value` still reports operand A.
- R7: A digit that is at least its modulus, but still fits in 7 bits, is treated as its value modulo that modulus. The result equals the result for the reduced code.
- R8: Every valid `out_value` lies in [-M/2, M/2 - 1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the operand buses and mode this cycle |
| in_cmp | input | 1 | 1 selects compare mode, 0 selects plain conversion |
| res_a | input | 49 | Operand A residue digits |
| res_b | input | 49 | Operand B residue digits (used in compare mode) |
| out_valid | output | 1 | Result of the input sampled 12 cycles earlier |
| out_value | output | 40 | Signed binary value of operand A |
| out_lt | output | 1 | A < B (compare mode only) |
| out_eq | output | 1 | A == B (compare mode only) |
| out_gt | output | 1 | A > B (compare mode only) |

## Verification
The value and all three flags of an input become visible together, 12 rising edges after the edge that samples `in_valid`. No output depends on any earlier cycle. The bench stamps every input with the cycle count at the time it is driven, queues the expected value and flags, and compares them at the falling edge on which `out_valid` is seen. It also checks that the current cycle count equals the stamp plus 12. Every idle falling edge serves as a check that the flags are 0. Back-to-back inputs and inputs separated by gaps confirm that neither pacing shifts the arrival cycle.

// File: rtl/rns_cvt_pkg.sv
package rns_cvt_pkg;
  localparam int NMOD = 7;
  localparam int RW   = 7;
  localparam int IN_W = NMOD * RW;

  function automatic longint unsigned modulus(input int i);
    case (i)
      0:       return 64'd11;
      1:       return 64'd23;
      2:       return 64'd31;
      3:       return 64'd73;
      4:       return 64'd89;
      5:       return 64'd127;
      default: return 64'd128;
    endcase
  endfunction

  function automatic longint unsigned range_of(input int n);
    longint unsigned p;
    p = 64'd1;
    for (int i = 0; i < n; i++) p = p * modulus(i);
    return p;
  endfunction

  localparam longint unsigned MRANGE = range_of(NMOD);

  // weight = (MRANGE/m) * inverse of (MRANGE/m) modulo m; always below MRANGE
  function automatic longint unsigned crt_weight(input int i);
    longint unsigned m, part, rem, hit;
    m    = modulus(i);
    part = MRANGE / m;
    rem  = part % m;
    hit  = 64'd0;
    for (longint unsigned k = 1; k < m; k++)
      if ((rem * k) % m == 64'd1) hit = k;
    return part * hit;
  endfunction
endpackage

// File: rtl/rns_weighted_sum.sv
module rns_weighted_sum
  import rns_cvt_pkg::*;
#(
  parameter int SUM_W = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic             cmp_in,
  input  logic [IN_W-1:0]  ra,
  input  logic [IN_W-1:0]  rb,
  output logic             v_out,
  output logic             cmp_out,
  output logic [SUM_W-1:0] a_out,
  output logic [SUM_W-1:0] b_out
);
  logic [SUM_W-1:0] term_a [NMOD];
  logic [SUM_W-1:0] term_b [NMOD];

  for (genvar g = 0; g < NMOD; g++) begin : g_term
    localparam logic [SUM_W-1:0] WG = SUM_W'(crt_weight(g));
    assign term_a[g] = SUM_W'(ra[g*RW +: RW]) * WG;
    assign term_b[g] = SUM_W'(rb[g*RW +: RW]) * WG;
  end

  logic [SUM_W-1:0] sum_a, sum_b;
  always_comb begin
    sum_a = '0;
    sum_b = '0;
    for (int i = 0; i < NMOD; i++) begin
      sum_a = sum_a + term_a[i];
      sum_b = sum_b + term_b[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out   <= 1'b0;
      cmp_out <= 1'b0;
    end else begin
      v_out   <= v_in;
      cmp_out <= cmp_in;
    end
  end

  always_ff @(posedge clk) begin
    a_out <= sum_a;
    b_out <= sum_b;
  end
endmodule

// File: rtl/rns_mod_step.sv
module rns_mod_step
  import rns_cvt_pkg::*;
#(
  parameter int SUM_W = 50,
  parameter int SHIFT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic             cmp_in,
  input  logic [SUM_W-1:0] a_in,
  input  logic [SUM_W-1:0] b_in,
  output logic             v_out,
  output logic             cmp_out,
  output logic [SUM_W-1:0] a_out,
  output logic [SUM_W-1:0] b_out
);
  localparam logic [SUM_W-1:0] LIM = SUM_W'(MRANGE << SHIFT);

  function automatic logic [SUM_W-1:0] cond_sub(input logic [SUM_W-1:0] x);
    return (x >= LIM) ? x - LIM : x;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out   <= 1'b0;
      cmp_out <= 1'b0;
    end else begin
      v_out   <= v_in;
      cmp_out <= cmp_in;
    end
  end

  always_ff @(posedge clk) begin
    a_out <= cond_sub(a_in);
    b_out <= cond_sub(b_in);
  end
endmodule

// File: rtl/rns_sign_cmp.sv
module rns_sign_cmp
  import rns_cvt_pkg::*;
#(
  parameter int SUM_W = 50,
  parameter int OUT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic             cmp_in,
  input  logic [SUM_W-1:0] a_in,
  input  logic [SUM_W-1:0] b_in,
  output logic             v_out,
  output logic [OUT_W-1:0] value_out,
  output logic             lt_out,
  output logic             eq_out,
  output logic             gt_out
);
  localparam logic [SUM_W-1:0] MW   = SUM_W'(MRANGE);
  localparam logic [SUM_W-1:0] HALF = SUM_W'(MRANGE / 2);

  function automatic logic [OUT_W-1:0] to_signed(input logic [SUM_W-1:0] x);
    logic [SUM_W-1:0] d;
    d = (x >= HALF) ? x - MW : x;
    return d[OUT_W-1:0];
  endfunction

  logic [OUT_W-1:0] sa, sb;
  logic             a_lt_b, a_eq_b;
  assign sa     = to_signed(a_in);
  assign sb     = to_signed(b_in);
  assign a_lt_b = $signed(sa) < $signed(sb);
  assign a_eq_b = (sa == sb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out  <= 1'b0;
      lt_out <= 1'b0;
      eq_out <= 1'b0;
      gt_out <= 1'b0;
    end else begin
      v_out  <= v_in;
      lt_out <= v_in & cmp_in & a_lt_b;
      eq_out <= v_in & cmp_in & a_eq_b;
      gt_out <= v_in & cmp_in & ~a_lt_b & ~a_eq_b;
    end
  end

  always_ff @(posedge clk) value_out <= sa;
endmodule

// File: rtl/rns_to_bin_cmp.sv
module rns_to_bin_cmp
  import rns_cvt_pkg::*;
#(
  parameter int SUM_W = 50,
  parameter int OUT_W = 40,
  parameter int NRED  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_cmp,
  input  logic [IN_W-1:0]  res_a,
  input  logic [IN_W-1:0]  res_b,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_value,
  output logic             out_lt,
  output logic             out_eq,
  output logic             out_gt
);
  localparam int LAT = NRED + 2;

  logic             st_v [NRED+1];
  logic             st_c [NRED+1];
  logic [SUM_W-1:0] st_a [NRED+1];
  logic [SUM_W-1:0] st_b [NRED+1];

  rns_weighted_sum #(.SUM_W(SUM_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .v_in(in_valid), .cmp_in(in_cmp),
    .ra(res_a), .rb(res_b),
    .v_out(st_v[0]), .cmp_out(st_c[0]), .a_out(st_a[0]), .b_out(st_b[0])
  );

  // largest multiple of M first, down to M itself
  for (genvar j = 0; j < NRED; j++) begin : g_red
    rns_mod_step #(.SUM_W(SUM_W), .SHIFT(NRED-1-j)) u_step (
      .clk(clk), .rst_n(rst_n),
      .v_in(st_v[j]), .cmp_in(st_c[j]), .a_in(st_a[j]), .b_in(st_b[j]),
      .v_out(st_v[j+1]), .cmp_out(st_c[j+1]), .a_out(st_a[j+1]), .b_out(st_b[j+1])
    );
  end

  // named events for the checker
  logic             red_done;
  logic [SUM_W-1:0] red_a_last;
  logic [SUM_W-1:0] red_b_last;
  assign red_done   = st_v[NRED];
  assign red_a_last = st_a[NRED];
  assign red_b_last = st_b[NRED];

  rns_sign_cmp #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .v_in(st_v[NRED]), .cmp_in(st_c[NRED]), .a_in(st_a[NRED]), .b_in(st_b[NRED]),
    .v_out(out_valid), .value_out(out_value),
    .lt_out(out_lt), .eq_out(out_eq), .gt_out(out_gt)
  );
endmodule

// File: rtl/rns_to_bin_cmp_chk.sv
module rns_to_bin_cmp_chk
  import rns_cvt_pkg::*;
#(
  parameter int LAT   = 12,
  parameter int SUM_W = 50,
  parameter int OUT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_cmp,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_value,
  input logic             out_lt,
  input logic             out_eq,
  input logic             out_gt,
  input logic             red_done,
  input logic [SUM_W-1:0] red_a_last,
  input logic [SUM_W-1:0] red_b_last
);
  localparam longint HALF_S = longint'(MRANGE / 2);

  logic [LAT-1:0] v_sh, c_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_sh <= '0;
      c_sh <= '0;
    end else begin
      v_sh <= {v_sh[LAT-2:0], in_valid};
      c_sh <= {c_sh[LAT-2:0], in_cmp};
    end
  end

  // R1 R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_sh[LAT-1]);

  // R5
  onehot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_sh[LAT-1]) |-> $countones({out_lt, out_eq, out_gt}) == 1);

  // R6
  quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || !c_sh[LAT-1]) |-> {out_lt, out_eq, out_gt} == 3'b000);

  // R8
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'($signed(out_value)) >= -HALF_S &&
                   longint'($signed(out_value)) <  HALF_S));

  // R7
  reduced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    red_done |-> (red_a_last < SUM_W'(MRANGE) && red_b_last < SUM_W'(MRANGE)));
endmodule

bind rns_to_bin_cmp rns_to_bin_cmp_chk #(.LAT(LAT), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmp(in_cmp),
  .out_valid(out_valid), .out_value(out_value),
  .out_lt(out_lt), .out_eq(out_eq), .out_gt(out_gt),
  .red_done(red_done), .red_a_last(red_a_last), .red_b_last(red_b_last)
);

// File: tb/sim_rns_to_bin_cmp.sv
`timescale 1ns/1ps
module sim_rns_to_bin_cmp;
  localparam longint unsigned MODS [7] = '{64'd11, 64'd23, 64'd31, 64'd73, 64'd89, 64'd127, 64'd128};
  localparam longint unsigned BM = 64'd11 * 64'd23 * 64'd31 * 64'd73 * 64'd89 * 64'd127 * 64'd128;
  localparam longint HB = longint'(BM / 2);
  localparam int DELAY = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_cmp = 1'b0;
  logic [48:0] res_a = '0;
  logic [48:0] res_b = '0;
  logic        out_valid;
  logic [39:0] out_value;
  logic        out_lt, out_eq, out_gt;

  always #4 clk = ~clk;

  rns_to_bin_cmp u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmp(in_cmp),
    .res_a(res_a), .res_b(res_b), .out_valid(out_valid), .out_value(out_value),
    .out_lt(out_lt), .out_eq(out_eq), .out_gt(out_gt)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    longint va;
    longint vb;
    bit     cmp;
    longint due;
    string  tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [48:0] enc(input longint unsigned u);
    logic [48:0] p;
    p = '0;
    for (int i = 0; i < 7; i++) p[i*7 +: 7] = 7'(u % MODS[i]);
    return p;
  endfunction

  function automatic longint as_signed(input longint unsigned u);
    return (u >= BM / 2) ? longint'(u) - longint'(BM) : longint'(u);
  endfunction

  function automatic longint unsigned to_raw(input longint x);
    return (x < 0) ? longint'(x + longint'(BM)) : x;
  endfunction

  function automatic longint rand34();
    logic [63:0] t;
    t = {$urandom, $urandom};
    return longint'({{30{t[33]}}, t[33:0]});
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic send_codes(input logic [48:0] pa, input logic [48:0] pb,
                            input longint va, input longint vb, input bit cmp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1; in_cmp = cmp; res_a = pa; res_b = pb;
    e.va = va; e.vb = vb; e.cmp = cmp; e.due = cyc + DELAY; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send_vals(input longint a, input longint b, input bit cmp, input string tag);
    send_codes(enc(to_raw(a)), enc(to_raw(b)), a, b, cmp, tag);
  endtask

  task automatic send_raw(input longint unsigned u, input string tag);
    send_codes(enc(u), enc(64'd0), as_signed(u), 0, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R4 unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          bit   xlt, xeq, xgt;
          e = q.pop_front();
          check(longint'($signed(out_value)) == e.va, {e.tag, " value"},
                longint'($signed(out_value)), e.va);
          check(cyc == e.due, "R4 arrival cycle", cyc, e.due);
          xlt = e.cmp && (e.va < e.vb);
          xeq = e.cmp && (e.va == e.vb);
          xgt = e.cmp && (e.va > e.vb);
          check({out_lt, out_eq, out_gt} == {xlt, xeq, xgt},
                e.cmp ? "R5 compare flags" : "R6 flags in convert mode",
                longint'({out_lt, out_eq, out_gt}), longint'({xlt, xeq, xgt}));
        end
      end else begin
        check({out_lt, out_eq, out_gt} == 3'b000, "R6 flags while idle",
              longint'({out_lt, out_eq, out_gt}), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", q.size());
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4521));
    repeat (3) @(negedge clk);
    check({out_valid, out_lt, out_eq, out_gt} == 4'b0000, "R1 during reset",
          longint'({out_valid, out_lt, out_eq, out_gt}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 after reset", longint'(out_valid), 0);

    // R2 and R3 corners
    send_vals(0, 0, 1'b0, "R2 zero");
    idle(3);
    send_vals(-1, 0, 1'b0, "R3 minus one");
    send_vals(longint'(64'h1_FFFF_FFFF), 0, 1'b0, "R2 max34");
    send_vals(-longint'(64'h2_0000_0000), 0, 1'b0, "R3 min34");
    send_raw(BM / 2 - 1, "R2 half minus one");
    send_raw(BM / 2, "R3 half");
    send_raw(BM - 1, "R3 top");
    idle(2);

    // R5 compare corners
    send_vals(5, 5, 1'b1, "R5 equal");
    send_vals(-7, 3, 1'b1, "R5 less");
    send_vals(3, -7, 1'b1, "R5 greater");
    send_codes(enc(BM / 2), enc(BM / 2 - 1), -HB, HB - 1, 1'b1, "R5 extremes");
    send_vals(-1, 0, 1'b1, "R5 neighbours");
    idle(1);

    // R7 digits above their modulus
    for (int k = 0; k < 20; k++) begin
      longint      x;
      logic [48:0] p;
      x = rand34();
      p = enc(to_raw(x));
      for (int i = 0; i < 6; i++)
        if (int'(p[i*7 +: 7]) + int'(MODS[i]) <= 127 && ((k + i) % 2 == 0))
          p[i*7 +: 7] = p[i*7 +: 7] + 7'(MODS[i]);
      send_codes(p, enc(0), x, 0, 1'b0, "R7 oversize digit");
    end

    // random mix, back to back and gapped
    for (int k = 0; k < 400; k++) begin
      longint a, b;
      bit     cm;
      a  = rand34();
      case ($urandom % 4)
        0:       b = a;
        1:       b = a + longint'($urandom % 3) - 1;
        default: b = rand34();
      endcase
      cm = ($urandom % 3) != 0;
      send_vals(a, b, cm, cm ? "R5 random" : "R2/R3 random");
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
    end

    idle(DELAY + 4);
    check(q.size() == 0, "R4 all results delivered", q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule